// File: doc/BRIEF.md
# Register Bridge to a Synthesizer Reconfiguration Port

This block sits on a plain 32-bit register bus and gives software a path into the dynamic reconfiguration port of a clock synthesizer. Software issues one port access by writing one command word. The word holds an arm bit, a direction bit, the target port address and the write data. The block turns that word into a single-cycle port strobe. It then waits for the port's ready and reports progress and read data through one status word. Software polls the busy flag in that word before it issues the next command.

Two small registers complete the set. The first drives the synthesizer's reset release and enable lines; the output runs only when both are set. The second selects the reference clock source. All register reads are registered: data appears one cycle after the read strobe.

The transfer engine is a three-state machine:
- `XS_IDLE`: nothing is in flight.
- `XS_ISSUE`: the one cycle in which the port strobe is driven.
- `XS_WAIT`: the engine holds until ready.

It has four transitions:
- `XS_IDLE`→`XS_ISSUE` on an armed command write.
- `XS_ISSUE`→`XS_IDLE` when ready is already high.
- `XS_ISSUE`→`XS_WAIT` when ready is low.
- `XS_WAIT`→`XS_IDLE` on ready.

Top module: `cfgport_bridge`

## Requirements
- R1: After reset every register reads zero, the control outputs are low, and no port access is in flight or started.
- R2: Offset 0x40 holds two bits that read back as written, and all other bits read zero. Bit 0 drives `core_rst_release` and bit 1 drives `synth_en`. `synth_run` is high only when both bits are set.
- R3: Offset 0x44 holds one bit (bit 0) that reads back as written and drives `src_sel`. All other bits read zero.
- R4: A write to offset 0x70 starts a port access only when bit 29 of the word is 1. Otherwise it has no effect, and offset 0x70 always reads zero.
- R5: In the command word, bit 28 = 1 selects a read and 0 selects a write. Bits 22:16 give the 7-bit port address, and bits 15:0 give the write data. `port_addr` and `port_wdata` carry these fields and stay stable while the access is in flight.
- R6: In the status word at 0x74, bit 16 (busy) is 1 from the cycle after a starting write until the edge at which `port_rdy` is sampled high.
- R7: `port_en` is high for exactly one cycle per access, in the cycle after the starting write. `port_we` is high in that same cycle only for writes, and is never high otherwise.
- R8: On a read access, `port_rdata` is captured at the edge where ready is sampled. Status bits 15:0 show the most recent completed read, and write accesses leave them unchanged.
- R9: A write to 0x70 while busy is 1 starts nothing and leaves the in-flight access unchanged. It sets the sticky error flag, status bit 17.
- R10: Reading the status word returns the error flag and then clears it. A new error in the same cycle keeps it set.
- R11: Read data appears on `reg_rdata` the cycle after `reg_rd_en`. Unmapped offsets read zero, and writes to the status offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (8) | Byte offset of the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| port_addr | output | PORT_AW (7) | Reconfiguration port address |
| port_wdata | output | DATA_W (16) | Reconfiguration port write data |
| port_en | output | 1 | One-cycle access strobe |
| port_we | output | 1 | Write qualifier, high with port_en on writes |
| port_rdata | input | DATA_W (16) | Reconfiguration port read data |
| port_rdy | input | 1 | Access complete |
| core_rst_release | output | 1 | Reset release bit of the control register |
| synth_en | output | 1 | Synthesizer enable bit |
| synth_run | output | 1 | High when both release and enable are set |
| src_sel | output | 1 | Reference clock source index |

## Verification
The hardest case to reach from the ports is a command write that lands while an earlier access is still in flight. The same case covers the error flag being reported once and then cleared by the very read that returned it. The bench stretches the port model's ready latency to several cycles. It issues two command writes back to back, then reads status on the next two cycles. The first read must show error and busy together, and the second must show busy alone. A later port read of the same address proves the rejected command never reached the port.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    // register offsets, indexed by the decoder
    localparam int NUM_REGS = 4;
    localparam int IDX_CTRL = 0;
    localparam int IDX_SRC  = 1;
    localparam int IDX_CMD  = 2;
    localparam int IDX_STAT = 3;
    localparam logic [11:0] REG_OFFS [NUM_REGS] = '{12'h040, 12'h044, 12'h070, 12'h074};

    // command word fields
    localparam int CW_ARM      = 29;
    localparam int CW_READ     = 28;
    localparam int CW_ADDR_LSB = 16;

    // status word fields
    localparam int SW_BUSY = 16;
    localparam int SW_ERR  = 17;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_ISSUE = 2'd1,
        XS_WAIT  = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/cfgport_addr_dec.sv
module cfgport_addr_dec
    import cfgport_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] hit
);

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_cmp
        assign hit[gi] = (addr == ADDR_W'(REG_OFFS[gi]));
    end

endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
    import cfgport_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              cmd_wr,
    output logic [31:0]       cmd_word,
    output logic              stat_rd,
    input  logic              busy,
    input  logic              err,
    input  logic [DATA_W-1:0] rdbuf,
    output logic [1:0]        ctrl_bits,
    output logic              src_bit
);

    localparam int CTRL_W = 2;

    logic [NUM_REGS-1:0] hit;
    logic [CTRL_W-1:0]   ctrl_q;
    logic                src_q;
    logic [31:0]         rdata_q;
    logic [31:0]         stat_word;
    logic [31:0]         rd_mux;

    cfgport_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .hit  (hit)
    );

    assign cmd_wr   = reg_wr_en && hit[IDX_CMD];
    assign cmd_word = reg_wdata;
    assign stat_rd  = reg_rd_en && hit[IDX_STAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            src_q  <= 1'b0;
        end else if (reg_wr_en) begin
            if (hit[IDX_CTRL]) ctrl_q <= reg_wdata[CTRL_W-1:0];
            if (hit[IDX_SRC])  src_q  <= reg_wdata[0];
        end
    end

    always_comb begin
        stat_word                = '0;
        stat_word[DATA_W-1:0]    = rdbuf;
        stat_word[SW_BUSY]       = busy;
        stat_word[SW_ERR]        = err;
    end

    always_comb begin
        rd_mux = '0;
        unique case (1'b1)
            hit[IDX_CTRL]: rd_mux[CTRL_W-1:0] = ctrl_q;
            hit[IDX_SRC]:  rd_mux[0]          = src_q;
            hit[IDX_STAT]: rd_mux             = stat_word;
            default:       rd_mux             = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (reg_rd_en) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;
    assign ctrl_bits = ctrl_q;
    assign src_bit   = src_q;

    // R11: the read register moves only when a read is strobed
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> $stable(reg_rdata));

endmodule

// File: rtl/cfgport_xfer_fsm.sv
module cfgport_xfer_fsm
    import cfgport_pkg::*;
#(
    parameter int PORT_AW = 7,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [31:0]        cmd_word,
    input  logic               stat_rd,
    output logic [PORT_AW-1:0] port_addr,
    output logic [DATA_W-1:0]  port_wdata,
    output logic               port_en,
    output logic               port_we,
    input  logic [DATA_W-1:0]  port_rdata,
    input  logic               port_rdy,
    output logic               busy,
    output logic               err,
    output logic [DATA_W-1:0]  rdbuf
);

    localparam int ADDR_MSB = CW_ADDR_LSB + PORT_AW - 1;

    xfer_state_e state_q, state_d;
    logic               launch;
    logic               collide;
    logic               done;
    logic               op_read_q;
    logic [PORT_AW-1:0] addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdbuf_q;
    logic               err_q;
    logic               unused_cmd;

    assign unused_cmd = ^cmd_word;

    assign launch  = cmd_wr && cmd_word[CW_ARM] && (state_q == XS_IDLE);
    assign collide = cmd_wr && (state_q != XS_IDLE);
    assign done    = port_rdy && (state_q != XS_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:  if (launch)   state_d = XS_ISSUE;
            XS_ISSUE: if (port_rdy) state_d = XS_IDLE;
                      else          state_d = XS_WAIT;
            XS_WAIT:  if (port_rdy) state_d = XS_IDLE;
            default:                state_d = XS_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        port_en = 1'b0;
        port_we = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            XS_IDLE: ;
            XS_ISSUE: begin
                port_en = 1'b1;
                port_we = !op_read_q;
                busy    = 1'b1;
            end
            XS_WAIT: busy = 1'b1;
            default: ;
        endcase
    end

    // command capture at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_read_q <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
        end else if (launch) begin
            op_read_q <= cmd_word[CW_READ];
            addr_q    <= cmd_word[ADDR_MSB:CW_ADDR_LSB];
            wdata_q   <= cmd_word[DATA_W-1:0];
        end
    end

    // read data capture at the ready edge
    always_ff @(posedge clk) begin
        if (!rst_n)                  rdbuf_q <= '0;
        else if (done && op_read_q)  rdbuf_q <= port_rdata;
    end

    // sticky error; a new collision wins over a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (collide) err_q <= 1'b1;
        else if (stat_rd) err_q <= 1'b0;
    end

    assign port_addr  = addr_q;
    assign port_wdata = wdata_q;
    assign rdbuf      = rdbuf_q;
    assign err        = err_q;

    assert_busy_after_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_word[CW_ARM] && !busy) |=> busy);

    assert_busy_ends_on_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(port_rdy));

    assert_en_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |=> !port_en);

    assert_we_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        port_we |-> port_en);

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !port_en) |-> ($stable(port_addr) && $stable(port_wdata)));

    assert_err_on_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> err);

    assert_err_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(cmd_wr && busy)) |=> !err);

endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
    import cfgport_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int PORT_AW = 7,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic               reg_rd_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [PORT_AW-1:0] port_addr,
    output logic [DATA_W-1:0]  port_wdata,
    output logic               port_en,
    output logic               port_we,
    input  logic [DATA_W-1:0]  port_rdata,
    input  logic               port_rdy,
    output logic               core_rst_release,
    output logic               synth_en,
    output logic               synth_run,
    output logic               src_sel
);

    logic              cmd_wr;
    logic [31:0]       cmd_word;
    logic              stat_rd;
    logic              busy;
    logic              err;
    logic [DATA_W-1:0] rdbuf;
    logic [1:0]        ctrl_bits;
    logic              src_bit;

    cfgport_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cmd_wr    (cmd_wr),
        .cmd_word  (cmd_word),
        .stat_rd   (stat_rd),
        .busy      (busy),
        .err       (err),
        .rdbuf     (rdbuf),
        .ctrl_bits (ctrl_bits),
        .src_bit   (src_bit)
    );

    cfgport_xfer_fsm #(.PORT_AW(PORT_AW), .DATA_W(DATA_W)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_word   (cmd_word),
        .stat_rd    (stat_rd),
        .port_addr  (port_addr),
        .port_wdata (port_wdata),
        .port_en    (port_en),
        .port_we    (port_we),
        .port_rdata (port_rdata),
        .port_rdy   (port_rdy),
        .busy       (busy),
        .err        (err),
        .rdbuf      (rdbuf)
    );

    assign core_rst_release = ctrl_bits[0];
    assign synth_en         = ctrl_bits[1];
    assign synth_run        = ctrl_bits[0] && ctrl_bits[1];
    assign src_sel          = src_bit;

    // R2: the synthesizer never runs while held in reset
    assert_run_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_release |-> !synth_run);

endmodule

// File: tb/sim_cfgport_bridge.sv
module sim_cfgport_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 8;
    localparam int PAW = 7;
    localparam int DW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic          reg_rd_en = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [PAW-1:0] port_addr;
    logic [DW-1:0] port_wdata;
    logic          port_en, port_we;
    logic [DW-1:0] port_rdata;
    logic          port_rdy;
    logic          core_rst_release, synth_en, synth_run, src_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgport_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .port_addr(port_addr), .port_wdata(port_wdata), .port_en(port_en),
        .port_we(port_we), .port_rdata(port_rdata), .port_rdy(port_rdy),
        .core_rst_release(core_rst_release), .synth_en(synth_en),
        .synth_run(synth_run), .src_sel(src_sel)
    );

    typedef struct { logic [31:0] exp; bit chk; string tag; } rd_item_t;
    typedef struct { logic we; logic [PAW-1:0] addr; logic [DW-1:0] data; } px_item_t;

    rd_item_t rdq[$];
    px_item_t pxq[$];
    int checks = 0;
    int errors = 0;
    int en_count = 0;
    int lat = 2;

    task automatic note(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // port slave model
    logic [DW-1:0] mem [128];
    logic [DW-1:0] rdout;
    logic          rdy_q;
    int            cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= 16'hA000 + 16'(i);
            rdy_q <= 1'b0; cnt <= 0; rdout <= '0;
        end else begin
            rdy_q <= 1'b0;
            if (port_en) begin
                if (port_we) mem[port_addr] <= port_wdata;
                else         rdout <= mem[port_addr];
                cnt <= lat;
            end else if (cnt > 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) rdy_q <= 1'b1;
            end
        end
    end
    assign port_rdata = rdout;
    assign port_rdy   = rdy_q;

    // register read monitor
    logic rd_seen = 1'b0;
    rd_item_t mon_it;
    always @(posedge clk) rd_seen <= reg_rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (rdq.size() == 0) note(1'b0, "R11 read with no expectation", reg_rdata, 32'h0);
            else begin
                mon_it = rdq.pop_front();
                if (mon_it.chk) note(reg_rdata === mon_it.exp, mon_it.tag, reg_rdata, mon_it.exp);
            end
        end
    end

    // port access monitor
    logic en_prev = 1'b0;
    px_item_t px_it;
    always @(negedge clk) begin
        if (rst_n) begin
            if (port_en) begin
                en_count++;
                if (en_prev) note(1'b0, "R7 enable wider than one cycle", 32'd1, 32'd0);
                if (pxq.size() == 0) note(1'b0, "R9 unexpected port access", {8'h0, port_we, port_addr, port_wdata}, 32'h0);
                else begin
                    px_it = pxq.pop_front();
                    note(port_we === px_it.we && port_addr === px_it.addr && (!px_it.we || port_wdata === px_it.data),
                         "R5 R7 port access fields", {8'h0, port_we, port_addr, port_wdata}, {8'h0, px_it.we, px_it.addr, px_it.data});
                end
            end else if (port_we) note(1'b0, "R7 write-enable without enable", 32'd1, 32'd0);
        end
        en_prev = port_en;
    end

    task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [AW-1:0] a, logic [31:0] e, string tag);
        rd_item_t it;
        it.exp = e; it.chk = 1'b1; it.tag = tag;
        rdq.push_back(it);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic poll_idle(string tag);
        rd_item_t it;
        bit done = 1'b0;
        it.exp = '0; it.chk = 1'b0; it.tag = tag;
        for (int k = 0; k < 100 && !done; k++) begin
            rdq.push_back(it);
            reg_rd_en = 1'b1; reg_addr = 8'h74;
            @(negedge clk);
            reg_rd_en = 1'b0;
            if (reg_rdata[16] == 1'b0) done = 1'b1;
        end
        if (!done) note(1'b0, tag, 32'd1, 32'd0);
    endtask

    task automatic port_write(logic [PAW-1:0] a, logic [15:0] d);
        px_item_t p;
        p.we = 1'b1; p.addr = a; p.data = d;
        pxq.push_back(p);
        bus_wr(8'h70, (32'd1 << 29) | (32'(a) << 16) | 32'(d));
    endtask

    task automatic port_read(logic [PAW-1:0] a);
        px_item_t p;
        p.we = 1'b0; p.addr = a; p.data = '0;
        pxq.push_back(p);
        bus_wr(8'h70, (32'd1 << 29) | (32'd1 << 28) | (32'(a) << 16));
    endtask

    logic [15:0] last_rd;
    int          en_before;

    initial begin : wdog
        #(CLK_PERIOD * 50000);
        note(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        note({port_en, port_we, core_rst_release, synth_en, synth_run, src_sel} == 6'b0,
             "R1 outputs low after reset", {26'h0, port_en, port_we, core_rst_release, synth_en, synth_run, src_sel}, 32'h0);
        bus_rd(8'h40, 32'h0, "R1 control reads zero");
        bus_rd(8'h44, 32'h0, "R1 source select reads zero");
        bus_rd(8'h74, 32'h0, "R1 status reads zero");
        bus_rd(8'h70, 32'h0, "R4 command offset reads zero");
        note(en_count == 0, "R1 no port access after reset", en_count, 0);

        // R2 control register
        bus_wr(8'h40, 32'h1);
        note({core_rst_release, synth_en, synth_run} == 3'b100, "R2 release only", {core_rst_release, synth_en, synth_run}, 3'b100);
        bus_wr(8'h40, 32'h3);
        note({core_rst_release, synth_en, synth_run} == 3'b111, "R2 both set runs", {core_rst_release, synth_en, synth_run}, 3'b111);
        bus_rd(8'h40, 32'h3, "R2 control readback");
        bus_wr(8'h40, 32'hFFFF_FFFE);
        note({core_rst_release, synth_en, synth_run} == 3'b010, "R2 enable only", {core_rst_release, synth_en, synth_run}, 3'b010);
        bus_rd(8'h40, 32'h2, "R2 upper bits dropped");

        // R3 source select
        bus_wr(8'h44, 32'h1);
        note(src_sel == 1'b1, "R3 select one", src_sel, 1);
        bus_rd(8'h44, 32'h1, "R3 select readback");
        bus_wr(8'h44, 32'hFFFF_FFFE);
        bus_rd(8'h44, 32'h0, "R3 select upper bits dropped");
        note(src_sel == 1'b0, "R3 select zero", src_sel, 0);

        // R5 R6 R8 port write then read back
        lat = 3;
        port_write(7'h05, 16'h1234);
        bus_rd(8'h74, 32'h0001_0000, "R6 busy the cycle after launch");
        poll_idle("R6 busy never cleared");
        bus_rd(8'h74, 32'h0000_0000, "R8 write leaves read data");
        port_read(7'h05);
        poll_idle("R6 busy never cleared");
        last_rd = 16'h1234;
        bus_rd(8'h74, {16'h0, last_rd}, "R8 read data of written address");

        port_read(7'h7F);
        poll_idle("R6 busy never cleared");
        last_rd = 16'hA07F;
        bus_rd(8'h74, {16'h0, last_rd}, "R5 top port address read");

        // R4 unarmed command
        en_before = en_count;
        bus_wr(8'h70, (32'd1 << 28) | (32'h03 << 16));
        bus_rd(8'h74, {16'h0, last_rd}, "R4 unarmed write not busy");
        repeat (4) @(negedge clk);
        note(en_count == en_before, "R4 unarmed write starts nothing", en_count, en_before);

        // R9 R10 collision while busy
        lat = 8;
        port_write(7'h09, 16'h1111);
        bus_wr(8'h70, (32'd1 << 29) | (32'h09 << 16) | 32'h2222);
        bus_rd(8'h74, {14'h0, 2'b11, last_rd}, "R9 error and busy after collision");
        bus_rd(8'h74, {14'h0, 2'b01, last_rd}, "R10 error cleared by status read");
        poll_idle("R6 busy never cleared");
        bus_rd(8'h74, {16'h0, last_rd}, "R10 error stays clear");
        lat = 1;
        port_read(7'h09);
        poll_idle("R6 busy never cleared");
        last_rd = 16'h1111;
        bus_rd(8'h74, {16'h0, last_rd}, "R9 ignored command did not reach port");

        // short latency read
        port_read(7'h00);
        poll_idle("R6 busy never cleared");
        last_rd = 16'hA000;
        bus_rd(8'h74, {16'h0, last_rd}, "R8 read with one-cycle latency");

        // R11 status write ignored, unmapped offsets
        bus_wr(8'h74, 32'hFFFF_FFFF);
        bus_rd(8'h74, {16'h0, last_rd}, "R11 status write ignored");
        bus_rd(8'h10, 32'h0, "R11 unmapped offset reads zero");
        bus_rd(8'h48, 32'h0, "R11 unmapped offset near select reads zero");

        repeat (3) @(negedge clk);
        note(en_count == 6, "R7 one enable per accepted command", en_count, 6);
        note(rdq.size() == 0 && pxq.size() == 0, "R7 scoreboard drained", rdq.size() + pxq.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule